// File: doc/BRIEF.md
# Seconds and Day Counter with Alarm Match

This block is the timekeeping core of a real-time clock. It counts whole seconds from a one-cycle `tick_1hz` pulse that a prescaler outside the block produces. The current time is held as a day number plus a count of seconds within the day. The seconds-of-day count is split into a low field and a high field, and each field is a separate register. A second set of registers holds an alarm time with the same fields. The block raises an alarm flag when the running time reaches the alarm time, and an update flag on every second. Each flag has its own enable that gates an interrupt output.

Software uses a synchronous register port with one write strobe, a 3-bit address and registered read data. Because the seconds count is split across two registers, a coherent time setting follows a fixed order. First write zero to the low field, which gives almost a full low-field period before any carry. Then write the day, the high field and finally the low field. A coherent read samples the high field before and after the other fields, and reads the day again if the high field moved.

Top module: `rtc_core`

## Requirements
- R1: After reset, every register reads zero and both interrupt outputs are low.
- R2: Each `tick_1hz` pulse adds one to the seconds-of-day count S = high*2^LO_W + low. The carry from the low field goes into the high field and the day is left unchanged. In a cycle with no tick and no write, no time field changes.
- R3: A tick taken when S is SEC_PER_DAY-1 or larger sets S to 0 and adds one to the day. The day counter wraps modulo 2^DAY_W.
- R4: The register offsets are 0 day, 1 seconds low, 2 seconds high, 3 alarm day, 4 alarm low, 5 alarm high, 6 interrupt enable and 7 interrupt flags. A write keeps only the low bits that fit the field width. A read returns the field zero-extended in the cycle after the address is presented.
- R5: A write in the same cycle as a tick loads the written field with the write data. The other fields still advance from the pre-tick count, including any carry.
- R6: After zero is written to the low field, the high field holds for the next 2^LO_W-1 ticks and increments on the tick after those.
- R7: Flag bit 0 (alarm) sets one cycle after the running day, high and low fields all become equal to the alarm registers, whether a tick or a write made them equal. It does not set again while the equality persists. The equal state right after reset does not set it.
- R8: Flag bit 1 (second update) sets on the clock edge that samples `tick_1hz`.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R10: `irq_alarm` is flag bit 0 AND enable bit 0, and `irq_sec` is flag bit 1 AND enable bit 1. Flags still latch while their enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data for the previous cycle's address |
| irq_alarm | output | 1 | Alarm interrupt level |
| irq_sec | output | 1 | Second-update interrupt level |

## Verification
The bench builds the core with DAY_W=3, LO_W=4, HI_W=4 and SEC_PER_DAY=200. In that configuration a full sweep of 1603 ticks passes through every seconds value, every low-to-high carry, every day rollover and the day-counter wrap itself. After each tick it checks the time against an arithmetic model. Writing all-ones to the narrow fields gives an out-of-range seconds value that has to recover. The sixteen-tick carry-free window after clearing the low field is short enough to walk tick by tick. Directed sequences then cover ticks that coincide with writes, alarm edges, the enables and the flag clear-versus-set race.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;

   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      OFF_DAY      = 3'd0,
      OFF_SEC_LO   = 3'd1,
      OFF_SEC_HI   = 3'd2,
      OFF_ALM_DAY  = 3'd3,
      OFF_ALM_LO   = 3'd4,
      OFF_ALM_HI   = 3'd5,
      OFF_IRQ_EN   = 3'd6,
      OFF_IRQ_FLAG = 3'd7
   } reg_off_e;

   localparam int IRQ_ALM_BIT = 0;
   localparam int IRQ_SEC_BIT = 1;
   localparam int IRQ_N       = 2;

endpackage

// File: rtl/rtc_tod_counter.sv
module rtc_tod_counter #(
   parameter int DAY_W       = 15,
   parameter int LO_W        = 8,
   parameter int HI_W        = 9,
   parameter int SEC_PER_DAY = 86400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_day,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [DAY_W-1:0] wday,
   input  logic [LO_W-1:0]  wlo,
   input  logic [HI_W-1:0]  whi,
   output logic [DAY_W-1:0] day_q,
   output logic [LO_W-1:0]  lo_q,
   output logic [HI_W-1:0]  hi_q
);

   localparam int SOD_W = LO_W + HI_W;
   localparam logic [SOD_W-1:0] LAST_SEC = SOD_W'(SEC_PER_DAY - 1);

   logic [SOD_W-1:0] sod;
   logic [SOD_W-1:0] sod_nxt;
   logic [DAY_W-1:0] day_nxt;
   logic             at_end;

   assign sod    = {hi_q, lo_q};
   // compare with >= so that an out-of-range value written by software wraps on the next tick
   assign at_end = (sod >= LAST_SEC);

   always_comb begin
      sod_nxt = sod;
      day_nxt = day_q;
      if (tick) begin
         if (at_end) begin
            sod_nxt = '0;
            day_nxt = day_q + DAY_W'(1);
         end else begin
            sod_nxt = sod + SOD_W'(1);
         end
      end
   end

   // a write to a field wins over the tick for that field only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         day_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
      end else begin
         day_q <= wr_day ? wday : day_nxt;
         lo_q  <= wr_lo  ? wlo  : sod_nxt[LO_W-1:0];
         hi_q  <= wr_hi  ? whi  : sod_nxt[SOD_W-1:LO_W];
      end
   end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TIME_W-1:0] now,
   input  logic [TIME_W-1:0] alarm,
   output logic              hit
);

   logic eq;
   logic eq_q;

   assign eq  = (now == alarm);
   assign hit = eq & ~eq_q;

   // eq_q starts at 1 so that the all-zero time and alarm after reset do not count as an arrival
   always_ff @(posedge clk) begin
      if (!rst_n) eq_q <= 1'b1;
      else        eq_q <= eq;
   end

endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_we,
   input  logic         en_we,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] flag_q,
   output logic [N-1:0] en_q,
   output logic [N-1:0] irq
);

   for (genvar i = 0; i < N; i++) begin : g_src
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            flag_q[i] <= 1'b0;
            en_q[i]   <= 1'b0;
         end else begin
            flag_q[i] <= set[i] | (flag_q[i] & ~(clr_we & wbits[i]));
            if (en_we) en_q[i] <= wbits[i];
         end
      end
      assign irq[i] = flag_q[i] & en_q[i];
   end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
   import rtc_core_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DAY_W       = 15,
   parameter int LO_W        = 8,
   parameter int HI_W        = 9,
   parameter int SEC_PER_DAY = 86400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wr_en,
   input  logic [2:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq_alarm,
   output logic              irq_sec
);

   localparam int TIME_W = DAY_W + HI_W + LO_W;

   if (DATA_W < DAY_W || DATA_W < LO_W || DATA_W < HI_W || DATA_W < IRQ_N) begin : g_bad_data_w
      $error("rtc_core: DATA_W narrower than a register field");
   end
   if (SEC_PER_DAY > (2 ** (LO_W + HI_W)) || SEC_PER_DAY <= (2 ** LO_W)) begin : g_bad_day_len
      $error("rtc_core: SEC_PER_DAY does not fit the seconds fields");
   end

   logic [DAY_W-1:0] day_q;
   logic [LO_W-1:0]  sec_lo_q;
   logic [HI_W-1:0]  sec_hi_q;
   logic [DAY_W-1:0] alm_day_q;
   logic [LO_W-1:0]  alm_lo_q;
   logic [HI_W-1:0]  alm_hi_q;
   logic [IRQ_N-1:0] irq_flag;
   logic [IRQ_N-1:0] irq_en;
   logic [IRQ_N-1:0] irq_vec;
   logic [IRQ_N-1:0] irq_set;
   logic             alarm_hit;
   logic [DATA_W-1:0] rd_mux;
   logic [DATA_W-1:0] rdata_q;
   logic              unused_wdata;

   assign unused_wdata = ^wdata;

   function automatic logic wsel(input logic [2:0] a, input reg_off_e o);
      return (a == o);
   endfunction

   rtc_tod_counter #(
      .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .SEC_PER_DAY(SEC_PER_DAY)
   ) u_tod (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick_1hz),
      .wr_day (wr_en && wsel(addr, OFF_DAY)),
      .wr_lo  (wr_en && wsel(addr, OFF_SEC_LO)),
      .wr_hi  (wr_en && wsel(addr, OFF_SEC_HI)),
      .wday   (wdata[DAY_W-1:0]),
      .wlo    (wdata[LO_W-1:0]),
      .whi    (wdata[HI_W-1:0]),
      .day_q  (day_q),
      .lo_q   (sec_lo_q),
      .hi_q   (sec_hi_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         alm_day_q <= '0;
         alm_lo_q  <= '0;
         alm_hi_q  <= '0;
      end else if (wr_en) begin
         if (wsel(addr, OFF_ALM_DAY)) alm_day_q <= wdata[DAY_W-1:0];
         if (wsel(addr, OFF_ALM_LO))  alm_lo_q  <= wdata[LO_W-1:0];
         if (wsel(addr, OFF_ALM_HI))  alm_hi_q  <= wdata[HI_W-1:0];
      end
   end

   rtc_alarm_match #(.TIME_W(TIME_W)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .now   ({day_q, sec_hi_q, sec_lo_q}),
      .alarm ({alm_day_q, alm_hi_q, alm_lo_q}),
      .hit   (alarm_hit)
   );

   always_comb begin
      irq_set              = '0;
      irq_set[IRQ_ALM_BIT] = alarm_hit;
      irq_set[IRQ_SEC_BIT] = tick_1hz;
   end

   rtc_irq_ctrl #(.N(IRQ_N)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (irq_set),
      .clr_we (wr_en && wsel(addr, OFF_IRQ_FLAG)),
      .en_we  (wr_en && wsel(addr, OFF_IRQ_EN)),
      .wbits  (wdata[IRQ_N-1:0]),
      .flag_q (irq_flag),
      .en_q   (irq_en),
      .irq    (irq_vec)
   );

   assign irq_alarm = irq_vec[IRQ_ALM_BIT];
   assign irq_sec   = irq_vec[IRQ_SEC_BIT];

   always_comb begin
      case (addr)
         OFF_DAY:      rd_mux = DATA_W'(day_q);
         OFF_SEC_LO:   rd_mux = DATA_W'(sec_lo_q);
         OFF_SEC_HI:   rd_mux = DATA_W'(sec_hi_q);
         OFF_ALM_DAY:  rd_mux = DATA_W'(alm_day_q);
         OFF_ALM_LO:   rd_mux = DATA_W'(alm_lo_q);
         OFF_ALM_HI:   rd_mux = DATA_W'(alm_hi_q);
         OFF_IRQ_EN:   rd_mux = DATA_W'(irq_en);
         default:      rd_mux = DATA_W'(irq_flag);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata_q <= '0;
      else        rdata_q <= rd_mux;
   end

   assign rdata = rdata_q;

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
   import rtc_core_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int DAY_W       = 15,
   parameter int LO_W        = 8,
   parameter int HI_W        = 9,
   parameter int SEC_PER_DAY = 86400
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_1hz,
   input logic              wr_en,
   input logic [2:0]        addr,
   input logic [DATA_W-1:0] wdata,
   input logic [DAY_W-1:0]  day_q,
   input logic [LO_W-1:0]   sec_lo_q,
   input logic [HI_W-1:0]   sec_hi_q,
   input logic [IRQ_N-1:0]  irq_flag
);

   localparam int SOD_W = LO_W + HI_W;
   localparam logic [SOD_W-1:0] LAST_SEC = SOD_W'(SEC_PER_DAY - 1);

   logic [SOD_W-1:0] sod;
   logic             flag_wr;
   assign sod     = {sec_hi_q, sec_lo_q};
   assign flag_wr = wr_en && (addr == OFF_IRQ_FLAG);

   // R2
   time_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_1hz && !wr_en) |=> ($stable(day_q) && $stable(sec_lo_q) && $stable(sec_hi_q)));

   // R2
   sec_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !wr_en && sod < LAST_SEC) |=> (sod == $past(sod) + SOD_W'(1) && $stable(day_q)));

   // R3
   day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !wr_en && sod >= LAST_SEC) |=> (sod == '0 && day_q == $past(day_q) + DAY_W'(1)));

   // R8
   sec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_1hz |=> irq_flag[IRQ_SEC_BIT]);

   // R9
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wdata[IRQ_SEC_BIT] && !tick_1hz) |=> !irq_flag[IRQ_SEC_BIT]);

   // R9
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag[IRQ_ALM_BIT] && !(flag_wr && wdata[IRQ_ALM_BIT])) |=> irq_flag[IRQ_ALM_BIT]);

endmodule

bind rtc_core rtc_core_chk #(
   .DATA_W(DATA_W), .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .SEC_PER_DAY(SEC_PER_DAY)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick_1hz (tick_1hz),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .day_q    (day_q),
   .sec_lo_q (sec_lo_q),
   .sec_hi_q (sec_hi_q),
   .irq_flag (irq_flag)
);

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
   import rtc_core_pkg::*;

   localparam int DATA_W = 16;
   localparam int DAY_W  = 3;
   localparam int LO_W   = 4;
   localparam int HI_W   = 4;
   localparam int SPD    = 200;
   localparam int LO_M   = 1 << LO_W;
   localparam int DAYS   = 1 << DAY_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick_1hz = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] addr = 3'd0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic irq_alarm, irq_sec;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtc_core #(
      .DATA_W(DATA_W), .DAY_W(DAY_W), .LO_W(LO_W), .HI_W(HI_W), .SEC_PER_DAY(SPD)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq_alarm(irq_alarm), .irq_sec(irq_sec)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic rd(input reg_off_e a, output int d);
      @(negedge clk);
      addr = a;
      @(negedge clk);
      d = int'(rdata);
   endtask

   task automatic wr(input reg_off_e a, input int d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = DATA_W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
   endtask

   task automatic tick_wr(input reg_off_e a, input int d);
      @(negedge clk);
      tick_1hz = 1'b1; wr_en = 1'b1; addr = a; wdata = DATA_W'(d);
      @(negedge clk);
      tick_1hz = 1'b0; wr_en = 1'b0;
   endtask

   task automatic chk_time(input string req, input int s, input int d);
      int v;
      rd(OFF_SEC_LO, v); chk(req, v, s % LO_M);
      rd(OFF_SEC_HI, v); chk(req, v, s / LO_M);
      rd(OFF_DAY, v);    chk(req, v, d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1 (run completed)");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int v;
      int s;
      int d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state of all registers and outputs
      for (int a = 0; a < 8; a++) begin
         rd(reg_off_e'(a), v);
         chk("R1", v, 0);
      end
      chk("R1 irq_alarm", int'(irq_alarm), 0);
      chk("R1 irq_sec", int'(irq_sec), 0);

      // R2 R3 full sweep over all seconds and past the day wrap
      s = 0; d = 0;
      for (int t = 0; t < DAYS * SPD + 3; t++) begin
         tick();
         s++;
         if (s == SPD) begin s = 0; d = (d + 1) % DAYS; end
         chk_time("R2/R3 sweep", s, d);
      end

      // R2 idle cycles leave time unchanged
      repeat (5) @(negedge clk);
      chk_time("R2 idle", s, d);

      // R4 width masking on write and zero-extended read
      wr(OFF_SEC_LO, 16'hFFFF); wr(OFF_SEC_HI, 16'hFFFF); wr(OFF_DAY, 16'hFFFF);
      wr(OFF_ALM_LO, 16'hFFFF); wr(OFF_ALM_HI, 16'hFFFF); wr(OFF_ALM_DAY, 16'hFFFF);
      wr(OFF_IRQ_EN, 16'hFFFF);
      repeat (2) @(negedge clk);
      wr(OFF_IRQ_FLAG, 16'hFFFF);
      rd(OFF_SEC_LO, v);   chk("R4 lo mask", v, LO_M - 1);
      rd(OFF_SEC_HI, v);   chk("R4 hi mask", v, (1 << HI_W) - 1);
      rd(OFF_DAY, v);      chk("R4 day mask", v, DAYS - 1);
      rd(OFF_ALM_LO, v);   chk("R4 alm lo", v, LO_M - 1);
      rd(OFF_ALM_HI, v);   chk("R4 alm hi", v, (1 << HI_W) - 1);
      rd(OFF_ALM_DAY, v);  chk("R4 alm day", v, DAYS - 1);
      rd(OFF_IRQ_EN, v);   chk("R4 irq en", v, 3);
      rd(OFF_IRQ_FLAG, v); chk("R9 w1c all", v, 0);
      wr(OFF_IRQ_EN, 0);

      // R3 out-of-range seconds value wraps on the next tick, day wraps modulo
      tick();
      chk_time("R3 out of range", 0, 0);

      // R5 write coinciding with a tick
      wr(OFF_DAY, 1); wr(OFF_SEC_HI, 2); wr(OFF_SEC_LO, 15);
      tick_wr(OFF_SEC_LO, 5);
      chk_time("R5 lo write wins, carry kept", 3 * LO_M + 5, 1);
      tick_wr(OFF_SEC_HI, 7);
      chk_time("R5 hi write wins, lo advances", 7 * LO_M + 6, 1);
      tick_wr(OFF_DAY, 4);
      chk_time("R5 day write wins", 7 * LO_M + 7, 4);

      // R6 carry-free window after clearing the low field
      wr(OFF_SEC_HI, 4); wr(OFF_SEC_LO, 0);
      for (int t = 1; t < LO_M; t++) begin
         tick();
         rd(OFF_SEC_HI, v); chk("R6 hi held", v, 4);
      end
      tick();
      rd(OFF_SEC_HI, v); chk("R6 hi carry", v, 5);
      rd(OFF_SEC_LO, v); chk("R6 lo zero", v, 0);

      // R7 R10 alarm arrival, enabled
      wr(OFF_DAY, 2); wr(OFF_SEC_HI, 1); wr(OFF_SEC_LO, 0);
      wr(OFF_ALM_DAY, 2); wr(OFF_ALM_HI, 1); wr(OFF_ALM_LO, 3);
      repeat (2) @(negedge clk);
      wr(OFF_IRQ_FLAG, 3);
      wr(OFF_IRQ_EN, 1);
      for (int t = 0; t < 2; t++) begin
         tick();
         @(negedge clk);
         chk("R7 before match", int'(irq_alarm), 0);
      end
      tick();
      @(negedge clk);
      chk("R7 R10 irq_alarm on match", int'(irq_alarm), 1);
      rd(OFF_IRQ_FLAG, v); chk("R7 flag bits", v, 3);
      wr(OFF_IRQ_FLAG, 1);
      chk("R9 irq_alarm cleared", int'(irq_alarm), 0);
      repeat (4) @(negedge clk);
      rd(OFF_IRQ_FLAG, v); chk("R7 no refire while equal", v, 2);

      // R10 alarm latches while masked
      wr(OFF_IRQ_EN, 0);
      wr(OFF_SEC_LO, 2);
      tick();
      @(negedge clk);
      chk("R10 masked irq_alarm", int'(irq_alarm), 0);
      rd(OFF_IRQ_FLAG, v); chk("R10 flag latched masked", v, 3);

      // R8 R10 second flag and output
      wr(OFF_IRQ_EN, 2);
      wr(OFF_IRQ_FLAG, 3);
      chk("R9 irq_sec clear", int'(irq_sec), 0);
      tick();
      chk("R8 R10 irq_sec after tick", int'(irq_sec), 1);
      wr(OFF_IRQ_FLAG, 1);
      chk("R9 write 1 to bit0 leaves bit1", int'(irq_sec), 1);
      wr(OFF_IRQ_FLAG, 2);
      chk("R9 bit1 cleared", int'(irq_sec), 0);
      wr(OFF_IRQ_EN, 0);
      tick();
      chk("R10 masked irq_sec", int'(irq_sec), 0);
      rd(OFF_IRQ_FLAG, v); chk("R8 flag latched masked", v & 2, 2);

      // R9 set wins over clear in the same cycle
      wr(OFF_IRQ_FLAG, 3);
      tick_wr(OFF_IRQ_FLAG, 2);
      rd(OFF_IRQ_FLAG, v); chk("R9 set beats clear", v & 2, 2);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule